// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block picks divider settings for a display PLL that runs from a fixed 96 MHz reference. A caller pulses `start_i` with a target pixel clock in kHz and an output profile: analog/serial or LVDS panel. The engine then walks every legal combination of the input divider n, the two feedback stages m1 and m2, and the first post-divider p1. Each candidate is checked against the feedback, VCO, post-divide and dot-clock windows. The engine keeps the candidate whose dot clock lies closest to the target.

The effective feedback ratio is the composite m = 5·(m1+2) + (m2+2). The VCO is ref·m/(n+2) and the dot clock is vco/(p1·p2), with both divisions truncated. The second post-divider p2 is not searched: it is fixed by the profile and by whether the target is below a profile-specific threshold. The slower single-channel value is preferred below that threshold. One shared iterative divider does all the arithmetic, a few quotient bits per cycle.

When the search ends, the block pulses `done_o` for one cycle and loads its registered result outputs. The result outputs are the fields, a packed divider word, a post-divider control word with the p1 select bit, the achieved clock and `found_o`. They hold until the next search completes.

Top module: `pll_div_search`

## Requirements
- R1: After reset `done_o` and `found_o` are low and every result output is zero.
- R2: The reported `dot_o` equals floor(floor(96000·m/(n+2)) / (p1·p2)) with m = 5·(m1+2)+(m2+2), for the reported fields.
- R3: A reported candidate has n in 1..6, m1 in 8..18, m2 in 3..7, p1 in 1..8, and m in 70..120.
- R4: A reported candidate has VCO in 1,400,000..2,800,000 kHz and dot clock in 20,000..400,000 kHz.
- R5: p1·p2 lies in 5..80 for the analog profile (`profile_i`=0) and in 7..98 for the LVDS profile (`profile_i`=1).
- R6: p2 is 10 when an analog target is below 200,000 kHz and 5 otherwise. p2 is 14 when an LVDS target is below 112,000 kHz and 7 otherwise.
- R7: The result has the least |dot − target| of all legal candidates. On a tie, the first in ascending n, then m1, then m2, then p1 order is kept.
- R8: `div_word_o` holds n in bits 23:16, m1 in bits 15:8 and m2 in bits 7:0.
- R9: `post_ctl_o` has exactly one bit set, bit 16+(p1−1), when a candidate is found.
- R10: If no candidate passes every window, `done_o` pulses with `found_o` low and all divider, clock and control outputs are zero.
- R11: `done_o` lasts one cycle. The results change only in a `done_o` cycle. A `start_i` seen while a search runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Search request pulse, taken only when idle |
| target_i | input | 24 | Target dot clock in kHz |
| profile_i | input | 1 | 0 analog/serial, 1 LVDS panel |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | A legal candidate was found |
| n_o | output | 3 | Chosen input divider |
| m1_o | output | 5 | Chosen first feedback stage |
| m2_o | output | 3 | Chosen second feedback stage |
| p1_o | output | 4 | Chosen first post-divider |
| p2_o | output | 4 | Second post-divider used |
| dot_o | output | 24 | Achieved dot clock in kHz |
| div_word_o | output | 24 | Packed n/m1/m2 word |
| post_ctl_o | output | 32 | p1 one-hot select at bits 23:16 |

## Verification
The search length depends on how many candidates survive the early window checks, so no result has a fixed latency. Every result is due in the one cycle where `done_o` is high, and all of them are registered in that cycle. The bench polls `done_o` on each falling edge and compares all outputs in the cycle where it first sees `done_o` high. It then checks that `done_o` is low one cycle later and that the results are unchanged a few cycles after that. For the ignored-start case, a second start is issued during a search, and the outputs must match the first request at its `done_o`.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned FREQ_W  = 24;
  localparam int unsigned REF_DEF = 96000;

  localparam int unsigned N_MIN  = 1,  N_MAX  = 6;
  localparam int unsigned M1_MIN = 8,  M1_MAX = 18;
  localparam int unsigned M2_MIN = 3,  M2_MAX = 7;
  localparam int unsigned P1_MIN = 1,  P1_MAX = 8;
  localparam int unsigned M_MIN  = 70, M_MAX  = 120;

  localparam int unsigned AN_P_MIN = 5,  AN_P_MAX = 80;
  localparam int unsigned AN_SLOW  = 10, AN_FAST  = 5,  AN_LIMIT = 200000;
  localparam int unsigned LV_P_MIN = 7,  LV_P_MAX = 98;
  localparam int unsigned LV_SLOW  = 14, LV_FAST  = 7,  LV_LIMIT = 112000;

  localparam int unsigned N_W  = $clog2(N_MAX + 1);
  localparam int unsigned M1_W = $clog2(M1_MAX + 1);
  localparam int unsigned M2_W = $clog2(M2_MAX + 1);
  localparam int unsigned P1_W = $clog2(P1_MAX + 1);
  localparam int unsigned P2_W = $clog2(LV_SLOW + 1);
  localparam int unsigned P_W  = $clog2(P1_MAX * LV_SLOW + 1);

  localparam int unsigned FLD_W    = 8;
  localparam int unsigned WORD_W   = 3 * FLD_W;
  localparam int unsigned CTL_W    = 32;
  localparam int unsigned MASK_LSB = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_MCHK, S_VDIV, S_PCHK, S_DDIV, S_FIN
  } srch_st_e;

  typedef struct packed {
    logic [N_W-1:0]    n;
    logic [M1_W-1:0]   m1;
    logic [M2_W-1:0]   m2;
    logic [P1_W-1:0]   p1;
    logic [FREQ_W-1:0] dot;
  } cand_t;
endpackage

// File: rtl/pll_div_iter.sv
module pll_div_iter #(
  parameter int unsigned NUM_W = 24,
  parameter int unsigned DEN_W = 7,
  parameter int unsigned STEPS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned ITER   = (NUM_W + STEPS - 1) / STEPS;
  localparam int unsigned PAD_W  = ITER * STEPS;
  localparam int unsigned CNT_W  = $clog2(ITER + 1);
  localparam int unsigned PROD_W = NUM_W + DEN_W + 1;

  logic [PAD_W-1:0] nq_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] num_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  logic [PAD_W-1:0] nq_s  [STEPS+1];
  logic [DEN_W-1:0] rem_s [STEPS+1];

  assign nq_s[0]  = nq_q;
  assign rem_s[0] = rem_q;

  // restoring division, STEPS quotient bits per cycle
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic [DEN_W:0] trial;
    logic           take;
    assign trial        = {rem_s[g], nq_s[g][PAD_W-1]};
    assign take         = trial >= {1'b0, den_q};
    assign rem_s[g+1]   = take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    assign nq_s[g+1]    = {nq_s[g][PAD_W-2:0], take};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nq_q   <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        nq_q  <= PAD_W'(num_i);
        rem_q <= '0;
        den_q <= den_i;
        num_q <= num_i;
        cnt_q <= CNT_W'(ITER);
      end else if (cnt_q != '0) begin
        nq_q   <= nq_s[STEPS];
        rem_q  <= rem_s[STEPS];
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = nq_q[NUM_W-1:0];

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (PROD_W'(quo_o) * PROD_W'(den_q) <= PROD_W'(num_q)) &&
               (PROD_W'(num_q) < (PROD_W'(quo_o) + 1'b1) * PROD_W'(den_q))); // R2
endmodule

// File: rtl/pll_best_track.sv
module pll_best_track
  import pll_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  cand_t             cand_i,
  input  logic [FREQ_W-1:0] err_i,
  output cand_t             best_o,
  output logic              have_o
);
  cand_t             best_q;
  logic [FREQ_W-1:0] err_q;
  logic              have_q;
  logic              better;

  // strict compare: an equal error never replaces an earlier candidate
  assign better = upd_i && (!have_q || (err_i < err_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q <= '0;
      err_q  <= '1;
      have_q <= 1'b0;
    end else if (clr_i) begin
      best_q <= '0;
      err_q  <= '1;
      have_q <= 1'b0;
    end else if (better) begin
      best_q <= cand_i;
      err_q  <= err_i;
      have_q <= 1'b1;
    end
  end

  assign best_o = best_q;
  assign have_o = have_q;

  AST_BEST_NO_WORSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !clr_i) |=> (err_q <= $past(err_q))); // R7
  AST_TIE_KEEPS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !clr_i && upd_i && (err_i == err_q)) |=> $stable(best_q)); // R7
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_pkg::*;
#(
  parameter int unsigned REF_KHZ     = REF_DEF,
  parameter int unsigned VCO_MIN_KHZ = 1400000,
  parameter int unsigned VCO_MAX_KHZ = 2800000,
  parameter int unsigned DOT_MIN_KHZ = 20000,
  parameter int unsigned DOT_MAX_KHZ = 400000,
  parameter int unsigned DIV_STEPS   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] target_i,
  input  logic              profile_i,
  output logic              done_o,
  output logic              found_o,
  output logic [N_W-1:0]    n_o,
  output logic [M1_W-1:0]   m1_o,
  output logic [M2_W-1:0]   m2_o,
  output logic [P1_W-1:0]   p1_o,
  output logic [P2_W-1:0]   p2_o,
  output logic [FREQ_W-1:0] dot_o,
  output logic [WORD_W-1:0] div_word_o,
  output logic [CTL_W-1:0]  post_ctl_o
);
  localparam int unsigned NUM_W = $clog2(REF_KHZ * M_MAX + 1);
  localparam int unsigned DEN_W = P_W;

  srch_st_e          st_q, st_d;
  logic [FREQ_W-1:0] tgt_q;
  logic              prof_q;
  logic [P2_W-1:0]   p2_q;
  logic [N_W-1:0]    n_q;
  logic [M1_W-1:0]   m1_q;
  logic [M2_W-1:0]   m2_q;
  logic [P1_W-1:0]   p1_q;
  logic [NUM_W-1:0]  vco_q;

  logic              div_go, div_done;
  logic [NUM_W-1:0]  div_num, div_quo;
  logic [DEN_W-1:0]  div_den;

  int unsigned       m_int, p_int, p_lo, p_hi, quo_int;
  logic              m_ok, p_ok, vco_ok, dot_ok;
  logic              last_n, last_m1, last_m2, last_p1;
  logic              adv_in, adv_out, step_in, step_out, take;
  logic [FREQ_W-1:0] dot_c, err_c;
  logic              launch;

  cand_t             cand_c, best;
  logic              have;
  cand_t             res_q;
  logic [P2_W-1:0]   p2_res_q;
  logic              found_q, done_q;

  assign launch  = (st_q == S_IDLE) && start_i;

  assign m_int   = 5 * (32'(m1_q) + 2) + 32'(m2_q) + 2;
  assign p_int   = 32'(p1_q) * 32'(p2_q);
  assign p_lo    = prof_q ? LV_P_MIN : AN_P_MIN;
  assign p_hi    = prof_q ? LV_P_MAX : AN_P_MAX;
  assign quo_int = 32'(div_quo);

  assign m_ok    = (m_int >= M_MIN) && (m_int <= M_MAX);
  assign p_ok    = (p_int >= p_lo) && (p_int <= p_hi);
  assign vco_ok  = (quo_int >= VCO_MIN_KHZ) && (quo_int <= VCO_MAX_KHZ);
  assign dot_ok  = (quo_int >= DOT_MIN_KHZ) && (quo_int <= DOT_MAX_KHZ);

  assign last_n  = n_q  == N_W'(N_MAX);
  assign last_m1 = m1_q == M1_W'(M1_MAX);
  assign last_m2 = m2_q == M2_W'(M2_MAX);
  assign last_p1 = p1_q == P1_W'(P1_MAX);

  assign dot_c   = FREQ_W'(div_quo);
  assign err_c   = (dot_c >= tgt_q) ? (dot_c - tgt_q) : (tgt_q - dot_c);

  always_comb begin
    st_d    = st_q;
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    adv_in  = 1'b0;
    adv_out = 1'b0;
    take    = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_MCHK;
      S_MCHK: begin
        if (m_ok) begin
          div_go  = 1'b1;
          div_num = NUM_W'(REF_KHZ * m_int);
          div_den = DEN_W'(32'(n_q) + 2);
          st_d    = S_VDIV;
        end else adv_out = 1'b1;
      end
      S_VDIV: if (div_done) begin
        if (vco_ok) st_d = S_PCHK;
        else        adv_out = 1'b1;
      end
      S_PCHK: begin
        if (p_ok) begin
          div_go  = 1'b1;
          div_num = vco_q;
          div_den = DEN_W'(p_int);
          st_d    = S_DDIV;
        end else adv_in = 1'b1;
      end
      S_DDIV: if (div_done) begin
        take   = dot_ok;
        adv_in = 1'b1;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    step_in  = adv_in && !last_p1;
    step_out = adv_out || (adv_in && last_p1);
    if (step_in)       st_d = S_PCHK;
    else if (step_out) st_d = (last_n && last_m1 && last_m2) ? S_FIN : S_MCHK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tgt_q  <= '0;
      prof_q <= 1'b0;
      p2_q   <= '0;
      n_q    <= '0;
      m1_q   <= '0;
      m2_q   <= '0;
      p1_q   <= '0;
      vco_q  <= '0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        tgt_q  <= target_i;
        prof_q <= profile_i;
        if (profile_i) p2_q <= (32'(target_i) < LV_LIMIT) ? P2_W'(LV_SLOW) : P2_W'(LV_FAST);
        else           p2_q <= (32'(target_i) < AN_LIMIT) ? P2_W'(AN_SLOW) : P2_W'(AN_FAST);
        n_q  <= N_W'(N_MIN);
        m1_q <= M1_W'(M1_MIN);
        m2_q <= M2_W'(M2_MIN);
        p1_q <= P1_W'(P1_MIN);
      end
      if (st_q == S_VDIV && div_done) begin
        vco_q <= div_quo;
        p1_q  <= P1_W'(P1_MIN);
      end
      if (step_in) p1_q <= p1_q + 1'b1;
      if (step_out) begin
        m2_q <= last_m2 ? M2_W'(M2_MIN) : m2_q + 1'b1;
        if (last_m2) begin
          m1_q <= last_m1 ? M1_W'(M1_MIN) : m1_q + 1'b1;
          if (last_m1) n_q <= n_q + 1'b1;
        end
      end
    end
  end

  pll_div_iter #(
    .NUM_W (NUM_W),
    .DEN_W (DEN_W),
    .STEPS (DIV_STEPS)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_go),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  assign cand_c = '{n: n_q, m1: m1_q, m2: m2_q, p1: p1_q, dot: dot_c};

  pll_best_track u_best (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .upd_i  (take),
    .cand_i (cand_c),
    .err_i  (err_c),
    .best_o (best),
    .have_o (have)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q    <= '0;
      p2_res_q <= '0;
      found_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (st_q == S_FIN);
      if (st_q == S_FIN) begin
        res_q    <= have ? best : '0;
        p2_res_q <= have ? p2_q : '0;
        found_q  <= have;
      end
    end
  end

  logic [P1_MAX-1:0] p1_mask;
  for (genvar g = 0; g < P1_MAX; g++) begin : g_mask
    assign p1_mask[g] = (res_q.p1 == P1_W'(g + 1));
  end

  assign done_o     = done_q;
  assign found_o    = found_q;
  assign n_o        = res_q.n;
  assign m1_o       = res_q.m1;
  assign m2_o       = res_q.m2;
  assign p1_o       = res_q.p1;
  assign p2_o       = p2_res_q;
  assign dot_o      = res_q.dot;
  assign div_word_o = {FLD_W'(res_q.n), FLD_W'(res_q.m1), FLD_W'(res_q.m2)};
  assign post_ctl_o = CTL_W'(p1_mask) << MASK_LSB;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R11
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> ($stable(res_q) && $stable(found_q) && $stable(p2_res_q))); // R11
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |=> ($stable(tgt_q) && $stable(prof_q))); // R11
  AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (32'(n_o) >= N_MIN && 32'(n_o) <= N_MAX && 32'(m1_o) >= M1_MIN &&
                 32'(m1_o) <= M1_MAX && 32'(m2_o) >= M2_MIN && 32'(m2_o) <= M2_MAX &&
                 32'(p1_o) >= P1_MIN && 32'(p1_o) <= P1_MAX)); // R3
  AST_DOT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (32'(dot_o) >= DOT_MIN_KHZ && 32'(dot_o) <= DOT_MAX_KHZ)); // R4
  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !found_q) |-> (div_word_o == '0 && post_ctl_o == '0 && dot_o == '0)); // R10
  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> ($countones(post_ctl_o) == 1)); // R9
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
  import pll_div_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] target = '0;
  logic              profile = 1'b0;

  logic              done, found, nf_done, nf_found;
  logic [N_W-1:0]    n_o, nf_n;
  logic [M1_W-1:0]   m1_o, nf_m1;
  logic [M2_W-1:0]   m2_o, nf_m2;
  logic [P1_W-1:0]   p1_o, nf_p1;
  logic [P2_W-1:0]   p2_o, nf_p2;
  logic [FREQ_W-1:0] dot_o, nf_dot;
  logic [WORD_W-1:0] word_o, nf_word;
  logic [CTL_W-1:0]  ctl_o, nf_ctl;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pll_div_search uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target), .profile_i(profile),
    .done_o(done), .found_o(found), .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o),
    .p2_o(p2_o), .dot_o(dot_o), .div_word_o(word_o), .post_ctl_o(ctl_o));

  // dot window placed out of reach: no candidate can pass
  pll_div_search #(.DOT_MIN_KHZ(500000), .DOT_MAX_KHZ(600000)) uut_nf (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target), .profile_i(profile),
    .done_o(nf_done), .found_o(nf_found), .n_o(nf_n), .m1_o(nf_m1), .m2_o(nf_m2),
    .p1_o(nf_p1), .p2_o(nf_p2), .dot_o(nf_dot), .div_word_o(nf_word), .post_ctl_o(nf_ctl));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_search(input int unsigned tgt, input bit lvds, output bit f,
                            output int unsigned rn, output int unsigned rm1,
                            output int unsigned rm2, output int unsigned rp1,
                            output int unsigned rp2, output int unsigned rdot);
    int unsigned best_err = 32'hFFFF_FFFF;
    int unsigned pmin = lvds ? 7 : 5;
    int unsigned pmax = lvds ? 98 : 80;
    rp2 = lvds ? ((tgt < 112000) ? 14 : 7) : ((tgt < 200000) ? 10 : 5);
    f = 1'b0; rn = 0; rm1 = 0; rm2 = 0; rp1 = 0; rdot = 0;
    for (int unsigned n = 1; n <= 6; n++)
      for (int unsigned a = 8; a <= 18; a++)
        for (int unsigned b = 3; b <= 7; b++)
          for (int unsigned c = 1; c <= 8; c++) begin
            int unsigned m = 5 * (a + 2) + (b + 2);
            int unsigned vco = 96000 * m / (n + 2);
            int unsigned p = c * rp2;
            int unsigned d = vco / p;
            int unsigned e = (d >= tgt) ? d - tgt : tgt - d;
            if (m < 70 || m > 120) continue;
            if (vco < 1400000 || vco > 2800000) continue;
            if (p < pmin || p > pmax) continue;
            if (d < 20000 || d > 400000) continue;
            if (e < best_err) begin
              best_err = e; f = 1'b1;
              rn = n; rm1 = a; rm2 = b; rp1 = c; rdot = d;
            end
          end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R11 done timeout", 0, 1);
  endtask

  task automatic compare(input int unsigned tgt, input bit lvds);
    bit f; int unsigned en, em1, em2, ep1, ep2, ed;
    ref_search(tgt, lvds, f, en, em1, em2, ep1, ep2, ed);
    chk("R4 found", found, f);
    chk("R7 n", n_o, en);
    chk("R7 m1", m1_o, em1);
    chk("R7 m2", m2_o, em2);
    chk("R7 p1", p1_o, ep1);
    chk("R6 p2", p2_o, ep2);
    chk("R2 dot", dot_o, ed);
    chk("R8 word", word_o, (en << 16) | (em1 << 8) | em2);
    chk("R9 post_ctl", ctl_o, 32'(1) << (16 + ep1 - 1));
    chk("R3 m window", ((5 * (m1_o + 2) + m2_o + 2) >= 70) && ((5 * (m1_o + 2) + m2_o + 2) <= 120), 1);
    chk("R5 p window", lvds ? (p1_o * p2_o >= 7 && p1_o * p2_o <= 98)
                            : (p1_o * p2_o >= 5 && p1_o * p2_o <= 80), 1);
  endtask

  task automatic run_one(input int unsigned tgt, input bit lvds, input bit retrigger);
    logic [WORD_W-1:0] w; logic [FREQ_W-1:0] d;
    @(negedge clk);
    target = FREQ_W'(tgt); profile = lvds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (retrigger) begin
      repeat (10) @(negedge clk);
      target = FREQ_W'(300000); profile = ~lvds; start = 1'b1;  // R11 must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    compare(tgt, lvds);
    w = word_o; d = dot_o;
    @(negedge clk);
    chk("R11 done width", done, 0);
    repeat (3) @(negedge clk);
    chk("R11 hold word", word_o, w);
    chk("R11 hold dot", dot_o, d);
    repeat (5) @(negedge clk);  // let the second instance finish too
  endtask

  initial begin
    int unsigned seed;
    chk("R1 done", done, 0);
    chk("R1 found", found, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 found", found, 0);
    chk("R1 word", word_o, 0);
    chk("R1 ctl", ctl_o, 0);
    chk("R1 dot", dot_o, 0);

    // R10: no candidate passes with the out-of-reach dot window
    @(negedge clk);
    target = FREQ_W'(100000); profile = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit a = 0, b = 0;
      for (int i = 0; i < 40000 && !(a && b); i++) begin
        @(negedge clk);
        if (nf_done) begin
          a = 1;
          chk("R10 found", nf_found, 0);
          chk("R10 word", nf_word, 0);
          chk("R10 ctl", nf_ctl, 0);
          chk("R10 dot", nf_dot, 0);
          chk("R10 p1", nf_p1, 0);
        end
        if (done) b = 1;
      end
      chk("R10 done seen", a, 1);
    end
    repeat (5) @(negedge clk);

    run_one(25175, 1'b0, 1'b0);   // R2
    run_one(199999, 1'b0, 1'b0);  // R6 slow side
    run_one(200000, 1'b0, 1'b0);  // R6 fast side
    run_one(111999, 1'b1, 1'b0);  // R6 LVDS slow
    run_one(112000, 1'b1, 1'b0);  // R6 LVDS fast
    run_one(20000, 1'b1, 1'b0);   // R5 p1=8 excluded at p2=14
    run_one(400000, 1'b0, 1'b0);  // R4 upper window
    run_one(10000, 1'b0, 1'b0);   // R4 below window
    run_one(65000, 1'b0, 1'b1);   // R11 retrigger ignored

    seed = $urandom(32'd1357);
    for (int k = 0; k < 5; k++) begin
      int unsigned t = 20000 + ($urandom() % 380001);
      run_one(t, 1'($urandom() % 2), 1'b0);  // R7 random
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule